// File: doc/BRIEF.md
# Extended Block Instruction Cache

This block caches decoded micro-ops grouped into extended blocks: runs of retired instructions that may be entered at several points but leave through one exit. A retired-instruction stream comes in on the fill side, one instruction per cycle. Each instruction carries its pointer, a class code and a micro-op payload. The fill logic gathers instructions until a conditional branch, an indirect branch or the length limit closes the run. An unconditional jump does not close a run. The closed run is then written into a direct-mapped array, tagged by the pointer of its exiting instruction.

Inside an entry the micro-ops are held newest-first: slot 0 carries the exiting instruction, and each higher slot carries the instruction one step earlier. A later run that leaves through the same exit but starts earlier therefore only appends older micro-ops in the higher slots. The entry stays in place and nothing is stored twice. On the lookup side a pointer is matched against the stored exit tags. A registered hit, length and slot vector are returned, and a fill/supply mode flag follows the lookups. While the cache is supplying, the fill input is ignored.

Top module: `xblk_cache`

## Requirements
- R1: A run closes on an instruction whose class is conditional branch (fill_cls = 1) or indirect branch (fill_cls = 2). The entry's tag is that instruction's pointer, and its length counts every instruction gathered since the previous close.
- R2: A run also closes on the instruction that brings its length to K (default 4). The next accepted instruction starts a new run.
- R3: Sequential (fill_cls = 0) and unconditional jump (fill_cls = 3) instructions do not close a run below K instructions, so the instructions at a jump target join the jump's run.
- R4: Slot j of hit_uops is bits [j*UOP_W +: UOP_W]. Slot 0 holds the exiting instruction's micro-op and slot j the one j instructions earlier. Slots at or above the returned length read as zero.
- R5: The set index is the low log2(SETS) bits of the exit pointer. A run whose exit maps onto a valid entry with a different tag replaces that entry completely.
- R6: A run with the same exit tag as a cached entry but a greater length writes only the slots from the old length upward and raises the length. The existing lower slots keep their contents.
- R7: A run with the same exit tag and a length no greater than the cached one leaves the entry unchanged.
- R8: A lookup presented with lkp_valid before a clock edge shows its hit, hit_len and hit_uops after that edge. An entry written at an edge is visible to a lookup sampled at the following edge. A closed run is written at the edge after its exiting instruction is accepted. Without lkp_valid all three outputs are zero.
- R9: A valid lookup that hits sets supply_mode and a valid lookup that misses clears it, both at the lookup's edge. The redirect input clears supply_mode and takes priority over a hit. With neither, the mode holds.
- R10: While supply_mode is 1, fill_valid is ignored: no instruction is gathered and no run closes.
- R11: Reset clears every entry and the partial run, puts the cache in fill mode and drives hit, hit_len and hit_uops to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fill_valid | input | 1 | A retired instruction is presented |
| fill_ip | input | IP_W | Pointer of the retired instruction |
| fill_cls | input | 2 | Class: 0 sequential, 1 conditional, 2 indirect, 3 unconditional jump |
| fill_uop | input | UOP_W | Micro-op payload of the retired instruction |
| lkp_valid | input | 1 | A lookup is presented |
| lkp_ip | input | IP_W | Pointer looked up against exit tags |
| redirect | input | 1 | Flush: force fill mode |
| hit | output | 1 | Registered lookup hit |
| hit_len | output | LEN_W | Valid length of the hit entry, 0 on miss |
| hit_uops | output | K*UOP_W | Slot vector of the hit entry, newest first |
| supply_mode | output | 1 | 1 while supplying, 0 while filling |

## Verification
Each lookup result is due one edge after the lookup is presented. A closed run reaches the array one edge after its exit instruction is accepted, so the earliest lookup that can see it is sampled two edges after acceptance. The directed cases probe that boundary in both directions. The mode flag moves at the same edge as the lookup result. A behavioural model in the bench steps at each rising edge in the same order as the hardware: it reads the pre-write array for the lookup, applies the pending write, then gathers the fill. All four outputs are compared with the model at every falling edge, halfway between updates, so no comparison depends on scheduling order at the edge.

// File: rtl/xblk_pkg.sv
package xblk_pkg;
  typedef enum logic [1:0] {
    CLS_SEQ  = 2'd0,
    CLS_COND = 2'd1,
    CLS_IND  = 2'd2,
    CLS_JMP  = 2'd3
  } ins_cls_e;
endpackage

// File: rtl/xblk_former.sv
// Gathers retired instructions into runs, newest micro-op in slot 0.
module xblk_former
  import xblk_pkg::*;
#(
  parameter int IP_W  = 16,
  parameter int UOP_W = 16,
  parameter int K     = 4,
  parameter int LEN_W = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_accept,
  input  logic [IP_W-1:0]           in_ip,
  input  logic [1:0]                in_cls,
  input  logic [UOP_W-1:0]          in_uop,
  output logic                      blk_valid,
  output logic [IP_W-1:0]           blk_tag,
  output logic [LEN_W-1:0]          blk_len,
  output logic [K-1:0][UOP_W-1:0]   blk_uops
);

  logic [LEN_W-1:0]        cnt_q, cnt_d, cnt_inc;
  logic [K-1:0][UOP_W-1:0] sh_q, sh_d;
  logic                    closes;
  logic                    bv_q;
  logic [IP_W-1:0]         bt_q;
  logic [LEN_W-1:0]        bl_q;
  logic [K-1:0][UOP_W-1:0] bu_q;
  ins_cls_e                cls;

  // next-state
  always_comb begin
    cls     = ins_cls_e'(in_cls);
    cnt_inc = cnt_q + 1'b1;
    closes  = in_accept &&
              (cls == CLS_COND || cls == CLS_IND || cnt_inc == LEN_W'(K));
    sh_d[0] = in_uop;
    for (int j = 1; j < K; j++) sh_d[j] = sh_q[j-1];
    if (!in_accept)  cnt_d = cnt_q;
    else if (closes) cnt_d = '0;
    else             cnt_d = cnt_inc;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bv_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bv_q  <= closes;
    end
  end

  // datapath registers, enabled
  always_ff @(posedge clk) begin
    if (in_accept) sh_q <= sh_d;
    if (closes) begin
      bt_q <= in_ip;
      bl_q <= cnt_inc;
      bu_q <= sh_d;
    end
  end

  assign blk_valid = bv_q;
  assign blk_tag   = bt_q;
  assign blk_len   = bl_q;
  assign blk_uops  = bu_q;

  a_r2_len_range: assert property (@(posedge clk) disable iff (!rst_n)
    blk_valid |-> (blk_len != '0 && blk_len <= LEN_W'(K)));

  a_r3_jmp_keeps_open: assert property (@(posedge clk) disable iff (!rst_n)
    (in_accept && cls == CLS_JMP && (cnt_q + 1'b1) != LEN_W'(K)) |=> !blk_valid);

endmodule

// File: rtl/xblk_array.sv
// Direct-mapped store of runs tagged by exit pointer; prefix growth; registered lookup.
module xblk_array #(
  parameter int IP_W  = 16,
  parameter int UOP_W = 16,
  parameter int K     = 4,
  parameter int LEN_W = 3,
  parameter int SETS  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_valid,
  input  logic [IP_W-1:0]           wr_tag,
  input  logic [LEN_W-1:0]          wr_len,
  input  logic [K-1:0][UOP_W-1:0]   wr_uops,
  input  logic                      rd_valid,
  input  logic [IP_W-1:0]           rd_ip,
  output logic                      rd_match,
  output logic                      hit_q,
  output logic [LEN_W-1:0]          len_q,
  output logic [K-1:0][UOP_W-1:0]   uops_q
);

  localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

  logic [SETS-1:0]          vld_q;
  logic [IP_W-1:0]          tag_a [SETS];
  logic [LEN_W-1:0]         len_a [SETS];
  logic [K-1:0][UOP_W-1:0]  dat_a [SETS];

  logic [IDX_W-1:0]         widx, ridx;
  logic                     same, fresh, grow, do_wr;
  logic [LEN_W-1:0]         old_len, rd_len;
  logic [K-1:0]             slot_we;
  logic                     hit_d;
  logic [LEN_W-1:0]         len_d;
  logic [K-1:0][UOP_W-1:0]  uops_d;

  // write decision
  always_comb begin
    widx    = wr_tag[IDX_W-1:0];
    old_len = len_a[widx];
    same    = vld_q[widx] && (tag_a[widx] == wr_tag);
    fresh   = !same;
    grow    = same && (wr_len > old_len);
    do_wr   = wr_valid && (fresh || grow);
  end

  // lookup side
  always_comb begin
    ridx     = rd_ip[IDX_W-1:0];
    rd_len   = len_a[ridx];
    rd_match = vld_q[ridx] && (tag_a[ridx] == rd_ip);
    hit_d    = rd_valid && rd_match;
    len_d    = hit_d ? rd_len : '0;
  end

  for (genvar j = 0; j < K; j++) begin : g_slot
    assign slot_we[j] = do_wr && (LEN_W'(j) < wr_len) &&
                        (fresh || LEN_W'(j) >= old_len);
    assign uops_d[j]  = (hit_d && LEN_W'(j) < rd_len) ? dat_a[ridx][j] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= '0;
      hit_q  <= 1'b0;
      len_q  <= '0;
      uops_q <= '0;
    end else begin
      if (do_wr) vld_q[widx] <= 1'b1;
      hit_q  <= hit_d;
      len_q  <= len_d;
      uops_q <= uops_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      tag_a[widx] <= wr_tag;
      len_a[widx] <= wr_len;
    end
    for (int j = 0; j < K; j++) begin
      if (slot_we[j]) dat_a[widx][j] <= wr_uops[j];
    end
  end

  a_r8_hit_has_len: assert property (@(posedge clk) disable iff (!rst_n)
    hit_q |-> (len_q != '0));

  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |=> (!hit_q && len_q == '0));

  a_r7_no_write_when_short: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && same && wr_len <= old_len) |-> (slot_we == '0));

endmodule

// File: rtl/xblk_mode.sv
// Fill/supply mode flag.
module xblk_mode (
  input  logic clk,
  input  logic rst_n,
  input  logic lkp_valid,
  input  logic lkp_match,
  input  logic redirect,
  output logic supply_q
);

  logic supply_d;

  always_comb begin
    if (redirect)       supply_d = 1'b0;
    else if (lkp_valid) supply_d = lkp_match;
    else                supply_d = supply_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) supply_q <= 1'b0;
    else        supply_q <= supply_d;
  end

  a_r9_redirect_fill: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !supply_q);

  a_r9_miss_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (lkp_valid && !lkp_match) |=> !supply_q);

endmodule

// File: rtl/xblk_cache.sv
module xblk_cache #(
  parameter int IP_W  = 16,
  parameter int UOP_W = 16,
  parameter int K     = 4,
  parameter int SETS  = 8,
  localparam int LEN_W = $clog2(K + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fill_valid,
  input  logic [IP_W-1:0]       fill_ip,
  input  logic [1:0]            fill_cls,
  input  logic [UOP_W-1:0]      fill_uop,
  input  logic                  lkp_valid,
  input  logic [IP_W-1:0]       lkp_ip,
  input  logic                  redirect,
  output logic                  hit,
  output logic [LEN_W-1:0]      hit_len,
  output logic [K*UOP_W-1:0]    hit_uops,
  output logic                  supply_mode
);

  logic                     accept;
  logic                     blk_valid;
  logic [IP_W-1:0]          blk_tag;
  logic [LEN_W-1:0]         blk_len;
  logic [K-1:0][UOP_W-1:0]  blk_uops;
  logic                     rd_match;
  logic [K-1:0][UOP_W-1:0]  uops_q;

  assign accept = fill_valid && !supply_mode;

  xblk_former #(.IP_W(IP_W), .UOP_W(UOP_W), .K(K), .LEN_W(LEN_W)) u_former (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_accept (accept),
    .in_ip     (fill_ip),
    .in_cls    (fill_cls),
    .in_uop    (fill_uop),
    .blk_valid (blk_valid),
    .blk_tag   (blk_tag),
    .blk_len   (blk_len),
    .blk_uops  (blk_uops)
  );

  xblk_array #(.IP_W(IP_W), .UOP_W(UOP_W), .K(K), .LEN_W(LEN_W), .SETS(SETS)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (blk_valid),
    .wr_tag   (blk_tag),
    .wr_len   (blk_len),
    .wr_uops  (blk_uops),
    .rd_valid (lkp_valid),
    .rd_ip    (lkp_ip),
    .rd_match (rd_match),
    .hit_q    (hit),
    .len_q    (hit_len),
    .uops_q   (uops_q)
  );

  xblk_mode u_mode (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_match (rd_match),
    .redirect  (redirect),
    .supply_q  (supply_mode)
  );

  assign hit_uops = uops_q;

  a_r10_fill_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    supply_mode |=> !blk_valid);

  a_r9_hit_enters_supply: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (supply_mode || $past(redirect)));

endmodule

// File: tb/tb_xblk_cache.sv
module tb_xblk_cache;
  localparam int IP_W  = 16;
  localparam int UOP_W = 16;
  localparam int K     = 4;
  localparam int SETS  = 8;
  localparam int LEN_W = $clog2(K + 1);

  logic                 clk;
  logic                 rst_n;
  logic                 fill_valid;
  logic [IP_W-1:0]      fill_ip;
  logic [1:0]           fill_cls;
  logic [UOP_W-1:0]     fill_uop;
  logic                 lkp_valid;
  logic [IP_W-1:0]      lkp_ip;
  logic                 redirect;
  logic                 hit;
  logic [LEN_W-1:0]     hit_len;
  logic [K*UOP_W-1:0]   hit_uops;
  logic                 supply_mode;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string cur_req = "R11";

  xblk_cache #(.IP_W(IP_W), .UOP_W(UOP_W), .K(K), .SETS(SETS)) dut (
    .clk(clk), .rst_n(rst_n),
    .fill_valid(fill_valid), .fill_ip(fill_ip), .fill_cls(fill_cls), .fill_uop(fill_uop),
    .lkp_valid(lkp_valid), .lkp_ip(lkp_ip), .redirect(redirect),
    .hit(hit), .hit_len(hit_len), .hit_uops(hit_uops), .supply_mode(supply_mode)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // ---------------- reference model ----------------
  bit               m_vld [SETS];
  logic [IP_W-1:0]  m_tag [SETS];
  int               m_len [SETS];
  logic [UOP_W-1:0] m_dat [SETS][K];
  bit               pb_v;
  logic [IP_W-1:0]  pb_tag;
  int               pb_len;
  logic [UOP_W-1:0] pb_dat [K];
  logic [UOP_W-1:0] runq [$];
  bit               m_mode;
  bit               e_hit;
  int               e_len;
  logic [K*UOP_W-1:0] e_uops;

  task automatic model_reset();
    for (int s = 0; s < SETS; s++) m_vld[s] = 0;
    pb_v = 0; runq.delete(); m_mode = 0;
    e_hit = 0; e_len = 0; e_uops = '0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int ri, wi;
      bit hn, n_hit, n_mode;
      int n_len;
      logic [K*UOP_W-1:0] n_uops;
      ri = int'(lkp_ip) % SETS;
      hn = m_vld[ri] && (m_tag[ri] == lkp_ip);
      n_hit = lkp_valid && hn;
      n_len = n_hit ? m_len[ri] : 0;
      n_uops = '0;
      for (int j = 0; j < n_len; j++) n_uops[j*UOP_W +: UOP_W] = m_dat[ri][j];
      n_mode = redirect ? 1'b0 : (lkp_valid ? hn : m_mode);
      if (pb_v) begin
        wi = int'(pb_tag) % SETS;
        if (m_vld[wi] && m_tag[wi] == pb_tag) begin
          if (pb_len > m_len[wi]) begin
            for (int j = m_len[wi]; j < pb_len; j++) m_dat[wi][j] = pb_dat[j];
            m_len[wi] = pb_len;
          end
        end else begin
          m_vld[wi] = 1; m_tag[wi] = pb_tag; m_len[wi] = pb_len;
          for (int j = 0; j < pb_len; j++) m_dat[wi][j] = pb_dat[j];
        end
      end
      pb_v = 0;
      if (fill_valid && !m_mode) begin
        runq.push_back(fill_uop);
        if (fill_cls == 2'd1 || fill_cls == 2'd2 || runq.size() == K) begin
          pb_v = 1; pb_tag = fill_ip; pb_len = runq.size();
          for (int j = 0; j < pb_len; j++) pb_dat[j] = runq[pb_len-1-j];
          runq.delete();
        end
      end
      m_mode = n_mode; e_hit = n_hit; e_len = n_len; e_uops = n_uops;
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("hit", 64'(hit), 64'(e_hit));
      chk("hit_len", 64'(hit_len), 64'(e_len));
      chk("hit_uops", 64'(hit_uops), 64'(e_uops));
      chk("supply_mode", 64'(supply_mode), 64'(m_mode));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic fill(input logic [15:0] ip, input logic [1:0] cls, input logic [15:0] uop);
    fill_valid = 1; fill_ip = ip; fill_cls = cls; fill_uop = uop;
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Direct check against values derived from the requirements.
  task automatic probe(input string req, input logic [15:0] ip, input bit redir,
                       input bit x_hit, input int x_len, input logic [63:0] x_uops,
                       input bit x_mode);
    lkp_valid = 1; lkp_ip = ip; redirect = redir;
    @(negedge clk);
    lkp_valid = 0; redirect = 0;
    cur_req = req;
    chk("probe hit", 64'(hit), 64'(x_hit));
    chk("probe len", 64'(hit_len), 64'(x_len));
    chk("probe uops", 64'(hit_uops), x_uops);
    chk("probe mode", 64'(supply_mode), 64'(x_mode));
  endtask

  initial begin
    rst_n = 0; fill_valid = 0; fill_ip = '0; fill_cls = '0; fill_uop = '0;
    lkp_valid = 0; lkp_ip = '0; redirect = 0;
    @(posedge clk); @(negedge clk);
    cur_req = "R11";
    chk("reset hit", 64'(hit), 64'd0);
    chk("reset len", 64'(hit_len), 64'd0);
    chk("reset uops", 64'(hit_uops), 64'd0);
    chk("reset mode", 64'(supply_mode), 64'd0);
    idle(1);
    rst_n = 1;
    idle(1);

    // R1: conditional branch closes a run of three
    cur_req = "R1";
    fill(16'h0100, 2'd0, 16'hA100);
    fill(16'h0101, 2'd0, 16'hA101);
    fill(16'h0102, 2'd1, 16'hA102);
    idle(2);
    probe("R1", 16'h0102, 0, 1, 3, 64'h0000_A100_A101_A102, 1);
    probe("R9", 16'h0200, 0, 0, 0, 64'h0, 0);

    // R3: jump does not close; target joins the run, indirect closes
    cur_req = "R3";
    fill(16'h0110, 2'd3, 16'hB110);
    fill(16'h0300, 2'd0, 16'hB300);
    fill(16'h0301, 2'd2, 16'hB301);
    idle(2);
    probe("R3", 16'h0301, 0, 1, 3, 64'h0000_B110_B300_B301, 1);
    probe("R9", 16'h0999, 0, 0, 0, 64'h0, 0);

    // R2: length limit closes at K, remainder starts anew
    cur_req = "R2";
    for (int i = 0; i < 5; i++) fill(16'h0400 + 16'(i), 2'd0, 16'hC400 + 16'(i));
    fill(16'h0405, 2'd1, 16'hC405);
    idle(2);
    probe("R2", 16'h0403, 0, 1, 4, 64'hC400_C401_C402_C403, 1);
    probe("R4", 16'h0405, 0, 1, 2, 64'h0000_0000_C404_C405, 1);
    probe("R4", 16'h0404, 0, 0, 0, 64'h0, 0);

    // R5: different tag on the same set replaces
    cur_req = "R5";
    fill(16'h050A, 2'd1, 16'hD50A);
    idle(2);
    probe("R5", 16'h0102, 0, 0, 0, 64'h0, 0);
    probe("R5", 16'h050A, 0, 1, 1, 64'h0000_0000_0000_D50A, 1);
    probe("R5", 16'h0000, 0, 0, 0, 64'h0, 0);

    // R6: longer run with same exit adds a prefix only
    cur_req = "R6";
    fill(16'h060C, 2'd1, 16'hE001);
    fill(16'h060A, 2'd0, 16'hE00A);
    fill(16'h060B, 2'd0, 16'hE00B);
    fill(16'h060C, 2'd1, 16'hE00C);
    idle(2);
    probe("R6", 16'h060C, 0, 1, 3, 64'h0000_E00A_E00B_E001, 1);
    probe("R6", 16'h0000, 0, 0, 0, 64'h0, 0);

    // R7: shorter run with same exit leaves entry unchanged
    cur_req = "R7";
    fill(16'h060C, 2'd1, 16'hF00C);
    idle(2);
    probe("R7", 16'h060C, 0, 1, 3, 64'h0000_E00A_E00B_E001, 1);

    // R10: in supply mode fills are ignored
    cur_req = "R10";
    fill(16'h070E, 2'd1, 16'h770E);
    idle(3);
    redirect = 1; @(negedge clk); redirect = 0;
    cur_req = "R9";
    chk("redirect mode", 64'(supply_mode), 64'd0);
    probe("R10", 16'h070E, 0, 0, 0, 64'h0, 0);

    // R9: redirect wins over a simultaneous hit
    probe("R9", 16'h060C, 1, 1, 3, 64'h0000_E00A_E00B_E001, 0);

    // R8: write visible only to the lookup one edge after the write
    cur_req = "R8";
    fill(16'h07A7, 2'd1, 16'h77A7);
    probe("R8", 16'h07A7, 0, 0, 0, 64'h0, 0);
    probe("R8", 16'h07A7, 0, 1, 1, 64'h0000_0000_0000_77A7, 1);
    idle(1);
    cur_req = "R8";
    chk("idle hit", 64'(hit), 64'd0);
    chk("idle mode holds", 64'(supply_mode), 64'd1);

    // R11: reset mid-run clears entries
    rst_n = 0; idle(2); rst_n = 1; idle(1);
    probe("R11", 16'h060C, 0, 0, 0, 64'h0, 0);

    // Mixed random traffic against the model
    cur_req = "R8 random";
    for (int c = 0; c < 2000; c++) begin
      fill_valid = ($urandom % 2) == 0;
      fill_ip    = 16'h0800 + 16'($urandom % 20);
      fill_cls   = (($urandom % 4) == 0) ? 2'd1 : 2'($urandom % 4);
      fill_uop   = 16'($urandom);
      lkp_valid  = ($urandom % 3) == 0;
      lkp_ip     = 16'h0800 + 16'($urandom % 20);
      redirect   = ($urandom % 16) == 0;
      @(negedge clk);
    end
    fill_valid = 0; lkp_valid = 0; redirect = 0;
    idle(2);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule